// File: doc/BRIEF.md
# Display Power-Save Sequencer

This block is the power-management unit of a small display controller. It holds a mode bit that software sets to put the display side to sleep and clears to run it. It also holds a read-only status bit that shows whether the memory controller is asleep right now. The block leaves reset in the sleeping mode, so software programs the rest of the chip first and then clears the mode bit.

While asleep, the block halts the refresh sequencer. It forces the panel data and control outputs low, stops the PWM waveform and forces the panel-function GPIO pins low. GPIO pins strapped for general use keep passing their values through. The strap is captured while reset is asserted and frozen when reset is released. Host accesses to the display buffer are arbitrated here. In normal mode they pass straight to the memory controller, which stays enabled. While asleep, a write raises the memory enable and waits for the controller's ready. It then issues the write and keeps the enable up for a fixed hold before it lets the controller sleep again. A read while asleep is refused at once with an error flag and zero data, and it does not wake the controller.

Top module: `disp_pwr_mgr`

## Requirements
- R1: After reset the control register at byte address 0xA0 reads 0x09 (mode bit 0 = 1, sleep-status bit 3 = 1). At the same time seq_run_o, mem_en_o, lcd_dat_o, lcd_ctl_o and pwm_o are all 0.
- R2: A register write to address 0xA0 loads bit 0 of the write data into the mode bit (1 = power save, 0 = normal). Writes to any other address leave the mode bit unchanged. Reads of other addresses return 0.
- R3: Bit 3 of register 0xA0 is read-only, and writing it has no effect. One cycle after mem_en_o is high it reads 0. One cycle after both mem_en_o and mem_rdy_i are low it reads 1.
- R4: A host write in power save raises mem_en_o and waits for mem_rdy_i. It then issues mem_cs_o with hst_ack_o in the same cycle and keeps mem_en_o high for HOLD_CYC further cycles (default 2), after which mem_en_o drops.
- R5: A host read in power save is acknowledged in the cycle it is presented, with hst_err_o = 1 and hst_rdata_o = 0. It produces no mem_cs_o, and mem_en_o stays 0.
- R6: In normal mode mem_en_o is 1. An access is acknowledged in the same cycle as mem_cs_o once mem_rdy_i is 1. Read data is mem_rdata_i, and hst_err_o is 0.
- R7: While in power save, seq_run_o, lcd_dat_o, lcd_ctl_o and pwm_o are held at 0. In normal mode the panel inputs pass through unchanged.
- R8: One clock after the mode bit is cleared, seq_run_o rises and the panel outputs are released on the same edge. One clock after the mode bit is set, both are withdrawn together.
- R9: The GPIO strap is sampled while reset is asserted. With strap = 1, gpio_o carries gpio_pnl_i in normal mode and 0 in power save. With strap = 0, gpio_o carries gpio_gen_i in both modes. Changing the strap after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pnl_gpio_i | input | 1 | GPIO strap: 1 = panel function, 0 = general purpose |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| hst_req_i | input | 1 | Host buffer access request, held until acknowledged |
| hst_we_i | input | 1 | Host access is a write |
| hst_addr_i | input | MEM_AW | Host buffer address |
| hst_wdata_i | input | MEM_DW | Host write data |
| hst_ack_o | output | 1 | Access completes in this cycle |
| hst_rdata_o | output | MEM_DW | Read data, valid with acknowledge |
| hst_err_o | output | 1 | Access refused |
| mem_en_o | output | 1 | Memory controller enable (wake) |
| mem_rdy_i | input | 1 | Memory controller awake and ready |
| mem_cs_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | MEM_AW | Memory address |
| mem_wdata_o | output | MEM_DW | Memory write data |
| mem_rdata_i | input | MEM_DW | Memory read data |
| seq_run_o | output | 1 | Refresh sequencer run enable |
| lcd_dat_i | input | LCD_W | Panel data from pixel path |
| lcd_ctl_i | input | CTL_W | Panel control from timing path |
| lcd_dat_o | output | LCD_W | Gated panel data |
| lcd_ctl_o | output | CTL_W | Gated panel control |
| pwm_i | input | 1 | PWM waveform, synchronous to clk |
| pwm_o | output | 1 | Gated PWM waveform |
| gpio_pnl_i | input | GPIO_W | Panel-function GPIO values |
| gpio_gen_i | input | GPIO_W | General-purpose GPIO values |
| gpio_o | output | GPIO_W | GPIO pin values |

## Verification
The bench times a write in power save against a ready that lags the enable by three cycles. A design that issued the write before ready, or dropped the enable early, would show a wrong wait count or enable profile. Reads in power save must be refused with no wake, and a later normal read then confirms that the buffer was left untouched. The mode transition is checked on the exact edge, because a design that released the panel outputs and restarted the sequencer on different cycles would glitch. Writes to the status bit and to foreign addresses are also tried, along with a strap that changes after reset; a design that let either reach its state would show up at the register read or on gpio_o.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAKE = 2'd1,
    ARB_HOLD = 2'd2
  } arb_st_e;

  localparam int unsigned MODE_BIT  = 0;
  localparam int unsigned SLEEP_BIT = 3;
endpackage

// File: rtl/dpm_rst_sync.sv
module dpm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn_o
);
  localparam int unsigned SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SW-2:0], 1'b1};
  end

  assign rst_sn_o = sync_q[SW-1];
endmodule

// File: rtl/dpm_regs.sv
module dpm_regs
  import dpm_pkg::*;
#(
  parameter int unsigned RA_W      = 8,
  parameter int unsigned RD_W      = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'hA0
) (
  input  logic            clk,
  input  logic            rst_sn,
  input  logic            cfg_pin_i,
  input  logic            wr_i,
  input  logic [RA_W-1:0] addr_i,
  input  logic [RD_W-1:0] wdata_i,
  output logic [RD_W-1:0] rdata_o,
  input  logic            asleep_i,
  output logic            ps_en_o,
  output logic            cfg_pnl_o
);
  logic addr_hit;
  logic ps_q, ps_d;
  logic cfg_q;

  assign addr_hit = (addr_i == RA_W'(CTRL_ADDR));

  // next state: only the mode bit is writable
  always_comb begin
    ps_d = ps_q;
    if (wr_i && addr_hit) ps_d = wdata_i[MODE_BIT];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) ps_q <= 1'b1;
    else         ps_q <= ps_d;
  end

  // strap follows the pin while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_sn) cfg_q <= cfg_pin_i;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_hit) begin
      rdata_o[MODE_BIT]  = ps_q;
      rdata_o[SLEEP_BIT] = asleep_i;
    end
  end

  assign ps_en_o   = ps_q;
  assign cfg_pnl_o = cfg_q;

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_i && addr_hit) |=> (ps_en_o == $past(wdata_i[MODE_BIT])));

  assert_foreign_ignored_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (!(wr_i && addr_hit)) |=> $stable(ps_en_o));
endmodule

// File: rtl/dpm_mem_arb.sv
module dpm_mem_arb
  import dpm_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 16,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          ps_en_i,
  input  logic          hst_req_i,
  input  logic          hst_we_i,
  input  logic [AW-1:0] hst_addr_i,
  input  logic [DW-1:0] hst_wdata_i,
  output logic          hst_ack_o,
  output logic [DW-1:0] hst_rdata_o,
  output logic          hst_err_o,
  output logic          mem_en_o,
  input  logic          mem_rdy_i,
  output logic          mem_cs_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          asleep_o
);
  localparam int unsigned HOLD_N = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
  localparam int unsigned CNT_W  = (HOLD_N < 2) ? 1 : $clog2(HOLD_N);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_N - 1);

  arb_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             asleep_q, asleep_d;

  // next-state and output decode
  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    hst_ack_o   = 1'b0;
    hst_err_o   = 1'b0;
    hst_rdata_o = '0;
    mem_cs_o    = 1'b0;
    unique case (st_q)
      ARB_IDLE: begin
        if (hst_req_i) begin
          if (!ps_en_i) begin
            if (mem_rdy_i) begin
              mem_cs_o  = 1'b1;
              hst_ack_o = 1'b1;
              if (!hst_we_i) hst_rdata_o = mem_rdata_i;
            end
          end else if (hst_we_i) begin
            st_d = ARB_WAKE;
          end else begin
            hst_ack_o = 1'b1;
            hst_err_o = 1'b1;
          end
        end
      end
      ARB_WAKE: begin
        if (!hst_req_i) begin
          st_d  = ARB_HOLD;
          cnt_d = CNT_LOAD;
        end else if (mem_rdy_i) begin
          mem_cs_o  = 1'b1;
          hst_ack_o = 1'b1;
          st_d      = ARB_HOLD;
          cnt_d     = CNT_LOAD;
        end
      end
      ARB_HOLD: begin
        if (cnt_q == '0) st_d = ARB_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ARB_IDLE;
    endcase
  end

  assign mem_en_o    = (st_q != ARB_IDLE) || !ps_en_i;
  assign mem_we_o    = hst_we_i;
  assign mem_addr_o  = hst_addr_i;
  assign mem_wdata_o = hst_wdata_i;

  always_comb begin
    asleep_d = asleep_q;
    if (mem_en_o)        asleep_d = 1'b0;
    else if (!mem_rdy_i) asleep_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q     <= ARB_IDLE;
      cnt_q    <= '0;
      asleep_q <= 1'b1;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      asleep_q <= asleep_d;
    end
  end

  assign asleep_o = asleep_q;

  assert_cs_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_cs_o |-> (mem_rdy_i && mem_en_o));

  assert_enable_held_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_cs_o && st_q == ARB_WAKE) |=> mem_en_o);

  assert_no_sleep_read_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_cs_o && !mem_we_o) |-> !ps_en_i);

  assert_read_no_wake_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ARB_IDLE && ps_en_i && hst_req_i && !hst_we_i) |=> (!mem_en_o || !ps_en_i));

  assert_status_awake_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_en_o |=> !asleep_o);

  assert_status_asleep_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!mem_en_o && !mem_rdy_i) |=> asleep_o);
endmodule

// File: rtl/dpm_panel_gate.sv
module dpm_panel_gate #(
  parameter int unsigned LCD_W  = 18,
  parameter int unsigned CTL_W  = 4,
  parameter int unsigned GPIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              ps_en_i,
  input  logic              cfg_pnl_i,
  input  logic [LCD_W-1:0]  lcd_dat_i,
  input  logic [CTL_W-1:0]  lcd_ctl_i,
  input  logic              pwm_i,
  input  logic [GPIO_W-1:0] gpio_pnl_i,
  input  logic [GPIO_W-1:0] gpio_gen_i,
  output logic              seq_run_o,
  output logic [LCD_W-1:0]  lcd_dat_o,
  output logic [CTL_W-1:0]  lcd_ctl_o,
  output logic              pwm_o,
  output logic [GPIO_W-1:0] gpio_o
);
  logic disp_on_q, disp_on_d;

  assign disp_on_d = !ps_en_i;

  // one flop drives both the sequencer enable and every output gate
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) disp_on_q <= 1'b0;
    else         disp_on_q <= disp_on_d;
  end

  assign seq_run_o = disp_on_q;
  assign lcd_dat_o = disp_on_q ? lcd_dat_i : '0;
  assign lcd_ctl_o = disp_on_q ? lcd_ctl_i : '0;
  assign pwm_o     = disp_on_q & pwm_i;

  generate
    for (genvar g = 0; g < GPIO_W; g++) begin : g_gpio
      assign gpio_o[g] = cfg_pnl_i ? (disp_on_q & gpio_pnl_i[g]) : gpio_gen_i[g];
    end
  endgenerate

  assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (ps_en_i && $past(ps_en_i)) |-> (lcd_dat_o == '0 && lcd_ctl_o == '0 && !pwm_o && !seq_run_o));

  assert_wake_together_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(ps_en_i) |=> (seq_run_o && lcd_dat_o == lcd_dat_i && pwm_o == pwm_i));

  assert_sleep_together_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(ps_en_i) |=> (!seq_run_o && lcd_dat_o == '0));

  assert_pnl_gpio_low_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg_pnl_i && ps_en_i && $past(ps_en_i)) |-> (gpio_o == '0));
endmodule

// File: rtl/disp_pwr_mgr.sv
module disp_pwr_mgr #(
  parameter int unsigned MEM_AW   = 16,
  parameter int unsigned MEM_DW   = 16,
  parameter int unsigned LCD_W    = 18,
  parameter int unsigned CTL_W    = 4,
  parameter int unsigned GPIO_W   = 4,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pnl_gpio_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              hst_req_i,
  input  logic              hst_we_i,
  input  logic [MEM_AW-1:0] hst_addr_i,
  input  logic [MEM_DW-1:0] hst_wdata_i,
  output logic              hst_ack_o,
  output logic [MEM_DW-1:0] hst_rdata_o,
  output logic              hst_err_o,
  output logic              mem_en_o,
  input  logic              mem_rdy_i,
  output logic              mem_cs_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [MEM_DW-1:0] mem_wdata_o,
  input  logic [MEM_DW-1:0] mem_rdata_i,
  output logic              seq_run_o,
  input  logic [LCD_W-1:0]  lcd_dat_i,
  input  logic [CTL_W-1:0]  lcd_ctl_i,
  output logic [LCD_W-1:0]  lcd_dat_o,
  output logic [CTL_W-1:0]  lcd_ctl_o,
  input  logic              pwm_i,
  output logic              pwm_o,
  input  logic [GPIO_W-1:0] gpio_pnl_i,
  input  logic [GPIO_W-1:0] gpio_gen_i,
  output logic [GPIO_W-1:0] gpio_o
);
  logic rst_sn;
  logic ps_en;
  logic cfg_pnl;
  logic asleep;

  dpm_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_sn_o (rst_sn)
  );

  dpm_regs #(.RA_W(8), .RD_W(8), .CTRL_ADDR(8'hA0)) u_regs (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .cfg_pin_i (cfg_pnl_gpio_i),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .asleep_i  (asleep),
    .ps_en_o   (ps_en),
    .cfg_pnl_o (cfg_pnl)
  );

  dpm_mem_arb #(.AW(MEM_AW), .DW(MEM_DW), .HOLD_CYC(HOLD_CYC)) u_arb (
    .clk         (clk),
    .rst_sn      (rst_sn),
    .ps_en_i     (ps_en),
    .hst_req_i   (hst_req_i),
    .hst_we_i    (hst_we_i),
    .hst_addr_i  (hst_addr_i),
    .hst_wdata_i (hst_wdata_i),
    .hst_ack_o   (hst_ack_o),
    .hst_rdata_o (hst_rdata_o),
    .hst_err_o   (hst_err_o),
    .mem_en_o    (mem_en_o),
    .mem_rdy_i   (mem_rdy_i),
    .mem_cs_o    (mem_cs_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .asleep_o    (asleep)
  );

  dpm_panel_gate #(.LCD_W(LCD_W), .CTL_W(CTL_W), .GPIO_W(GPIO_W)) u_gate (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .ps_en_i    (ps_en),
    .cfg_pnl_i  (cfg_pnl),
    .lcd_dat_i  (lcd_dat_i),
    .lcd_ctl_i  (lcd_ctl_i),
    .pwm_i      (pwm_i),
    .gpio_pnl_i (gpio_pnl_i),
    .gpio_gen_i (gpio_gen_i),
    .seq_run_o  (seq_run_o),
    .lcd_dat_o  (lcd_dat_o),
    .lcd_ctl_o  (lcd_ctl_o),
    .pwm_o      (pwm_o),
    .gpio_o     (gpio_o)
  );
endmodule

// File: tb/disp_pwr_mgr_tb_top.sv
module disp_pwr_mgr_tb_top;
  localparam int CLK_PER = 10;
  localparam int AW = 16, DW = 16, LW = 18, CW = 4, GW = 4, HOLD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pin = 1'b1;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'hA0, reg_wdata = 8'h00, reg_rdata;
  logic hst_req = 1'b0, hst_we = 1'b0;
  logic [AW-1:0] hst_addr = '0;
  logic [DW-1:0] hst_wdata = '0, hst_rdata;
  logic hst_ack, hst_err;
  logic mem_en, mem_rdy, mem_cs, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic seq_run;
  logic [LW-1:0] lcd_dat = '0, lcd_dat_o;
  logic [CW-1:0] lcd_ctl = '0, lcd_ctl_o;
  logic pwm = 1'b0, pwm_o;
  logic [GW-1:0] gpio_pnl = '0, gpio_gen = '0, gpio_o;

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] mem_arr [16];
  logic [DW-1:0] shadow  [16];
  logic [2:0] rdy_sh;

  always #(CLK_PER/2) clk = ~clk;

  disp_pwr_mgr #(.MEM_AW(AW), .MEM_DW(DW), .LCD_W(LW), .CTL_W(CW),
                 .GPIO_W(GW), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pnl_gpio_i(cfg_pin),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .hst_req_i(hst_req), .hst_we_i(hst_we), .hst_addr_i(hst_addr), .hst_wdata_i(hst_wdata),
    .hst_ack_o(hst_ack), .hst_rdata_o(hst_rdata), .hst_err_o(hst_err),
    .mem_en_o(mem_en), .mem_rdy_i(mem_rdy), .mem_cs_o(mem_cs), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .seq_run_o(seq_run), .lcd_dat_i(lcd_dat), .lcd_ctl_i(lcd_ctl),
    .lcd_dat_o(lcd_dat_o), .lcd_ctl_o(lcd_ctl_o), .pwm_i(pwm), .pwm_o(pwm_o),
    .gpio_pnl_i(gpio_pnl), .gpio_gen_i(gpio_gen), .gpio_o(gpio_o)
  );

  // memory controller model: ready follows enable three cycles later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_sh <= '0;
    else        rdy_sh <= {rdy_sh[1:0], mem_en};
  end
  assign mem_rdy   = rdy_sh[2];
  assign mem_rdata = mem_arr[mem_addr[3:0]];
  always @(posedge clk) begin
    if (mem_cs && mem_we) mem_arr[mem_addr[3:0]] <= mem_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] exp_lcd(input logic ps, input logic [LW-1:0] d);
    return ps ? '0 : d;
  endfunction

  function automatic logic [GW-1:0] exp_gpio(input logic strap, input logic ps,
                                             input logic [GW-1:0] p, input logic [GW-1:0] g);
    return strap ? (ps ? '0 : p) : g;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; cfg_pin = strap; hst_req = 1'b0; reg_wr = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    cfg_pin = ~strap;
    for (int i = 0; i < 16; i++) shadow[i] = mem_arr[i];
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'hA0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic host_op(input logic we, input logic [3:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] rd, output logic err, output int waited);
    hst_req = 1'b1; hst_we = we; hst_addr = AW'(a); hst_wdata = d;
    waited = 0;
    #1;
    while (!hst_ack && waited < 50) begin
      @(posedge clk); @(negedge clk); #1;
      waited++;
    end
    rd = hst_rdata; err = hst_err;
    @(posedge clk); @(negedge clk);
    hst_req = 1'b0;
    if (we && !err) shadow[a] = d;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] rd;
    logic err;
    int w;
    logic ps;
    void'($urandom(32'h1d5e_0a77));
    for (int i = 0; i < 16; i++) mem_arr[i] = DW'(i * 3 + 1);

    do_reset(1'b1);
    // R1 reset state
    check("R1 reg", 32'(reg_rdata), 32'h09);
    check("R1 seq", 32'(seq_run), 0);
    check("R1 en", 32'(mem_en), 0);
    lcd_dat = '1; lcd_ctl = '1; pwm = 1'b1; gpio_pnl = '1; #1;
    check("R1 lcd", 32'(lcd_dat_o), 0);
    check("R7 pwm", 32'(pwm_o), 0);
    check("R9 gpio panel low after strap flip", 32'(gpio_o), 0);

    // R2 foreign address and R3 status write ignored
    reg_write(8'hA1, 8'h00);
    check("R2 foreign write", 32'(reg_rdata), 32'h09);
    reg_addr = 8'hA1; #1;
    check("R2 foreign read", 32'(reg_rdata), 0);
    reg_addr = 8'hA0;
    reg_write(8'hA0, 8'h01);
    check("R3 status write ignored", 32'(reg_rdata), 32'h09);

    // R5 read refused in sleep
    host_op(1'b0, 4'd5, '0, rd, err, w);
    check("R5 err", 32'(err), 1);
    check("R5 data", 32'(rd), 0);
    check("R5 wait", 32'(w), 0);
    check("R5 en", 32'(mem_en), 0);

    // R4 write in sleep
    host_op(1'b1, 4'd5, 16'hBEEF, rd, err, w);
    check("R4 wait for ready", 32'(w), 4);
    check("R4 err", 32'(err), 0);
    check("R4 en hold1", 32'(mem_en), 1);
    check("R3 awake status", 32'(reg_rdata), 32'h01);
    cyc(1);
    check("R4 en hold2", 32'(mem_en), 1);
    cyc(1);
    check("R4 en dropped", 32'(mem_en), 0);
    cyc(5);
    check("R3 asleep again", 32'(reg_rdata), 32'h09);

    // R8 exit on one edge
    lcd_dat = 18'h2A5A5; lcd_ctl = 4'h9; pwm = 1'b1; gpio_pnl = 4'h6;
    reg_addr = 8'hA0; reg_wdata = 8'h08; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk); reg_wr = 1'b0;
    check("R8 not yet seq", 32'(seq_run), 0);
    check("R8 not yet lcd", 32'(lcd_dat_o), 0);
    @(posedge clk); @(negedge clk);
    check("R8 seq on", 32'(seq_run), 1);
    check("R8 lcd on", 32'(lcd_dat_o), 32'h2A5A5);
    check("R7 ctl pass", 32'(lcd_ctl_o), 9);
    check("R9 gpio panel pass", 32'(gpio_o), 6);
    check("R3 bit3 write ignored", 32'(reg_rdata[3]), 0);

    // R6 normal access
    cyc(3);
    check("R6 en", 32'(mem_en), 1);
    host_op(1'b0, 4'd5, '0, rd, err, w);
    check("R6 read data", 32'(rd), 32'hBEEF);
    check("R6 err", 32'(err), 0);
    check("R6 wait", 32'(w), 0);

    // R8 entry on one edge
    reg_addr = 8'hA0; reg_wdata = 8'h01; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk); reg_wr = 1'b0;
    check("R8 still on", 32'(seq_run), 1);
    @(posedge clk); @(negedge clk);
    check("R8 seq off", 32'(seq_run), 0);
    check("R8 lcd off", 32'(lcd_dat_o), 0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [3:0] a;
      logic [DW-1:0] d;
      op = $urandom_range(0, 9);
      a  = 4'($urandom);
      d  = DW'($urandom);
      if (op < 2) begin
        reg_write((op == 0) ? 8'hA0 : 8'($urandom), 8'($urandom));
      end else if (op < 6) begin
        ps = reg_rdata[0];
        host_op(1'b0, a, '0, rd, err, w);
        check(ps ? "R5 rand err" : "R6 rand err", 32'(err), 32'(ps));
        check(ps ? "R5 rand data" : "R6 rand data", 32'(rd), ps ? 0 : 32'(shadow[a]));
      end else begin
        host_op(1'b1, a, d, rd, err, w);
        check("R4 rand write err", 32'(err), 0);
      end
      cyc(1);
      ps = reg_rdata[0];
      lcd_dat = LW'($urandom); lcd_ctl = CW'($urandom); pwm = 1'($urandom);
      gpio_pnl = GW'($urandom); gpio_gen = GW'($urandom); #1;
      check("R7 rand lcd", 32'(lcd_dat_o), 32'(exp_lcd(ps, lcd_dat)));
      check("R7 rand seq", 32'(seq_run), 32'(!ps));
      check("R9 rand gpio", 32'(gpio_o), 32'(exp_gpio(1'b1, ps, gpio_pnl, gpio_gen)));
    end

    // R9 general-purpose strap
    do_reset(1'b0);
    gpio_gen = 4'hA; gpio_pnl = 4'h5; #1;
    check("R9 general pass in sleep", 32'(gpio_o), 32'hA);
    check("R1 reg after second reset", 32'(reg_rdata), 32'h09);
    reg_write(8'hA0, 8'h00);
    gpio_gen = 4'h3; #1;
    check("R9 general pass normal", 32'(gpio_o), 32'h3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule